// File: doc/BRIEF.md
# Memory-Mapped Address Select Decoder

This block turns the upper bits of a 16-bit processor address into active-low select lines for four memory regions of a small 8-bit computer: program ROM, the keyboard matrix, video RAM and main RAM. Only address bits 15 down to 10 are decoded, so every region is a whole number of 1 KB pages. A 3-to-8 primary decoder splits the lower 32 KB into eight 4 KB slices. It is enabled only while bit 15 is low and the row-strobe qualifier `ras_n` is low. Inside the fourth slice, bits 11 and 10 separate an unused gap, the keyboard page and the video page.

A strap vector stands between the decoder outputs and the region logic. Each strap bit connects one decoder output. Clearing a bit leaves that output unconnected, which is how the installed ROM and RAM sizes are set on the board. The upper 32 KB is decoded by a second, one-bit decoder. Its two strap bits enable main RAM in the 16 KB halves of that space. The four selects are registered, so each one follows the address and strobes by one clock edge.

Top module: `addr_select_decoder`

## Requirements
- R1: While `rst_n` is low, and after reset until the first decoded access, all four selects are high.
- R2: The selects change only at a rising clock edge. They reflect `addr`, `rd_n`, `ras_n` and `strap` as sampled at the previous rising edge (one cycle of latency).
- R3: When `ras_n` was high at the sampling edge, no select is low, whatever the address is.
- R4: Address bits 9..0 have no effect on any select.
- R5: With bit 15 low and A14..A12 equal to 0, 1 or 2 (0x0000-0x2FFF), `rom_sel_n` goes low when strap bit number A14..A12 is set. For example, 0x01AC selects ROM.
- R6: In slice 3 with A11..A10 = 2'b10 (0x3800-0x3BFF, for example 0x380A), `kbd_sel_n` goes low only when `rd_n` is low and strap bit 3 is set.
- R7: In slice 3 with A11..A10 = 2'b11 (0x3C00-0x3FFF, for example 0x3CAA), `vid_sel_n` goes low when strap bit 3 is set, for reads and writes alike.
- R8: Slice 3 with A11 low (0x3000-0x37FF) asserts no select.
- R9: With bit 15 low and A14..A12 equal to 4..7 (0x4000-0x7FFF), `ram_sel_n` goes low when strap bit number A14..A12 is set.
- R10: With bit 15 high, `ram_sel_n` goes low when strap bit 8 (for A14 = 0) or strap bit 9 (for A14 = 1) is set.
- R11: A cleared strap bit makes the region it connects produce no select.
- R12: At most one of the four selects is low in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the select registers |
| rst_n | input | 1 | Active-low synchronous reset; forces all selects high |
| addr | input | 16 | Processor address bus; only bits 15..10 are decoded |
| rd_n | input | 1 | Active-low read strobe; qualifies the keyboard select |
| ras_n | input | 1 | Active-low row-strobe qualifier; enables both decoders |
| strap | input | 10 | Bits 0..7 connect primary decoder outputs 0..7; bits 8..9 connect the upper RAM halves |
| rom_sel_n | output | 1 | Active-low ROM select |
| kbd_sel_n | output | 1 | Active-low keyboard select |
| vid_sel_n | output | 1 | Active-low video RAM select |
| ram_sel_n | output | 1 | Active-low main RAM select |

## Verification
The bench builds the decoder with its default region layout: three ROM slices, with the I/O slice at index 3, so slices 4 to 7 fall to RAM. This exposes every one of the eight primary outputs and both upper halves to the stimulus. A sweep over all 64 upper-bit patterns, run under several strap vectors and both read polarities, reaches every boundary between ROM, the gap, the keyboard, video and RAM. It also reaches every combination of an open and a closed strap bit that the mask can see.

// File: rtl/addr_sel_pkg.sv
package addr_sel_pkg;
    // Address geometry
    localparam int ADDR_W  = 16;
    localparam int DEC_LSB = 10;                       // lowest decoded bit
    localparam int OCT_W   = 3;                        // primary decoder code width
    localparam int N_PRI   = 1 << OCT_W;               // primary slices
    localparam int UP_W    = 1;                        // upper decoder code width
    localparam int N_UP    = 1 << UP_W;                // upper RAM halves
    localparam int STRAP_W = N_PRI + N_UP;
    localparam int SUB_W   = ADDR_W - 1 - OCT_W - DEC_LSB;

    // Sub-page codes inside the I/O slice
    localparam logic [SUB_W-1:0] SUB_KBD = 2'b10;
    localparam logic [SUB_W-1:0] SUB_VID = 2'b11;

    // Registered select bundle, active low
    typedef struct packed {
        logic rom_n;
        logic kbd_n;
        logic vid_n;
        logic ram_n;
    } sel_t;

    localparam sel_t SEL_IDLE = '{rom_n: 1'b1, kbd_n: 1'b1, vid_n: 1'b1, ram_n: 1'b1};
endpackage

// File: rtl/addr_code_decoder.sv
module addr_code_decoder #(
    parameter int CODE_W = 3,
    localparam int N_OUT = 1 << CODE_W
) (
    input  logic              en_n,
    input  logic [CODE_W-1:0] code,
    output logic [N_OUT-1:0]  y_n
);
    // One active-low output per code; all high when disabled
    for (genvar i = 0; i < N_OUT; i++) begin : g_out
        assign y_n[i] = !(!en_n && (code == CODE_W'(i)));
    end
endmodule

// File: rtl/addr_strap_mask.sv
module addr_strap_mask #(
    parameter int N = 8
) (
    input  logic [N-1:0] dec_n,
    input  logic [N-1:0] strap,
    output logic [N-1:0] link_n
);
    // A broken strap leaves its line floating high (inactive)
    for (genvar i = 0; i < N; i++) begin : g_link
        assign link_n[i] = strap[i] ? dec_n[i] : 1'b1;
    end
endmodule

// File: rtl/addr_region_map.sv
module addr_region_map
    import addr_sel_pkg::*;
#(
    parameter int ROM_SLICES = 3,
    parameter int IO_SLICE   = 3
) (
    input  logic [N_PRI-1:0] slice_n,
    input  logic [N_UP-1:0]  upper_n,
    input  logic [SUB_W-1:0] sub,
    input  logic             rd_n,
    output logic             rom_hit,
    output logic             kbd_hit,
    output logic             vid_hit,
    output logic             ram_hit
);
    logic io_hit;

    always_comb begin
        rom_hit = 1'b0;
        ram_hit = 1'b0;
        for (int i = 0; i < N_PRI; i++) begin
            if (!slice_n[i]) begin
                if (i < ROM_SLICES) begin
                    rom_hit = 1'b1;
                end else if (i > IO_SLICE) begin
                    ram_hit = 1'b1;
                end
            end
        end
        for (int j = 0; j < N_UP; j++) begin
            if (!upper_n[j]) begin
                ram_hit = 1'b1;
            end
        end
        io_hit  = !slice_n[IO_SLICE];
        kbd_hit = io_hit && (sub == SUB_KBD) && !rd_n;
        vid_hit = io_hit && (sub == SUB_VID);
    end
endmodule

// File: rtl/addr_select_decoder.sv
module addr_select_decoder
    import addr_sel_pkg::*;
#(
    parameter int ROM_SLICES = 3,
    parameter int IO_SLICE   = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  addr,
    input  logic               rd_n,
    input  logic               ras_n,
    input  logic [STRAP_W-1:0] strap,
    output logic               rom_sel_n,
    output logic               kbd_sel_n,
    output logic               vid_sel_n,
    output logic               ram_sel_n
);
    logic [N_PRI-1:0] pri_dec_n;
    logic [N_PRI-1:0] pri_link_n;
    logic [N_UP-1:0]  up_dec_n;
    logic [N_UP-1:0]  up_link_n;
    logic             pri_en_n;
    logic             up_en_n;
    logic             rom_hit, kbd_hit, vid_hit, ram_hit;
    logic             unused_low_bits;
    sel_t             sel_d, sel_q;

    // Bits below the decode window never take part
    assign unused_low_bits = ^addr[DEC_LSB-1:0];

    // Lower half: enabled by A15 low together with the row strobe
    assign pri_en_n = addr[ADDR_W-1] | ras_n;
    // Upper half: enabled by A15 high together with the row strobe
    assign up_en_n  = !addr[ADDR_W-1] | ras_n;

    addr_code_decoder #(.CODE_W(OCT_W)) u_pri_dec (
        .en_n (pri_en_n),
        .code (addr[ADDR_W-2 -: OCT_W]),
        .y_n  (pri_dec_n)
    );

    addr_code_decoder #(.CODE_W(UP_W)) u_up_dec (
        .en_n (up_en_n),
        .code (addr[ADDR_W-2 -: UP_W]),
        .y_n  (up_dec_n)
    );

    addr_strap_mask #(.N(N_PRI)) u_pri_mask (
        .dec_n  (pri_dec_n),
        .strap  (strap[N_PRI-1:0]),
        .link_n (pri_link_n)
    );

    addr_strap_mask #(.N(N_UP)) u_up_mask (
        .dec_n  (up_dec_n),
        .strap  (strap[STRAP_W-1:N_PRI]),
        .link_n (up_link_n)
    );

    addr_region_map #(
        .ROM_SLICES (ROM_SLICES),
        .IO_SLICE   (IO_SLICE)
    ) u_map (
        .slice_n (pri_link_n),
        .upper_n (up_link_n),
        .sub     (addr[DEC_LSB +: SUB_W]),
        .rd_n    (rd_n),
        .rom_hit (rom_hit),
        .kbd_hit (kbd_hit),
        .vid_hit (vid_hit),
        .ram_hit (ram_hit)
    );

    always_comb begin
        sel_d       = SEL_IDLE;
        sel_d.rom_n = !rom_hit;
        sel_d.kbd_n = !kbd_hit;
        sel_d.vid_n = !vid_hit;
        sel_d.ram_n = !ram_hit;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= SEL_IDLE;
        end else begin
            sel_q <= sel_d;
        end
    end

    assign rom_sel_n = sel_q.rom_n;
    assign kbd_sel_n = sel_q.kbd_n;
    assign vid_sel_n = sel_q.vid_n;
    assign ram_sel_n = sel_q.ram_n;
endmodule

// File: rtl/addr_select_decoder_chk.sv
module addr_select_decoder_chk
    import addr_sel_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic [ADDR_W-1:0]  addr,
    input logic               rd_n,
    input logic               ras_n,
    input logic [STRAP_W-1:0] strap,
    input logic               rom_sel_n,
    input logic               kbd_sel_n,
    input logic               vid_sel_n,
    input logic               ram_sel_n
);
    // R12: never two regions at once
    p_one_region_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({!rom_sel_n, !kbd_sel_n, !vid_sel_n, !ram_sel_n}) <= 1);

    // R3: an idle row strobe yields an idle bus one edge later
    p_ras_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ras_n) |-> (rom_sel_n && kbd_sel_n && vid_sel_n && ram_sel_n));

    // R6: keyboard only on reads
    p_kbd_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !kbd_sel_n |-> (!$past(rd_n) && $past(addr[15:10]) == 6'b001110));

    // R7: video only in its own page
    p_vid_page_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !vid_sel_n |-> ($past(addr[15:10]) == 6'b001111 && $past(strap[3])));

    // R5 / R11: ROM only below 0x3000 and only through a closed strap
    p_rom_strap_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !rom_sel_n |-> ($past(addr[15:12]) < 4'd3 && $past(strap[addr[14:12]])));

    // R9 / R10: RAM only at 0x4000 and above
    p_ram_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !ram_sel_n |-> ($past(addr[15]) || $past(addr[14])));
endmodule

bind addr_select_decoder addr_select_decoder_chk u_chk (.*);

// File: tb/addr_select_decoder_bench.sv
module addr_select_decoder_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] addr = 16'h0000;
    logic        rd_n = 1'b1;
    logic        ras_n = 1'b1;
    logic [9:0]  strap = 10'h3FF;
    logic        rom_sel_n, kbd_sel_n, vid_sel_n, ram_sel_n;

    int checks = 0;
    int errors = 0;

    always #5ns clk = ~clk;

    addr_select_decoder u_addr_select_decoder (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr      (addr),
        .rd_n      (rd_n),
        .ras_n     (ras_n),
        .strap     (strap),
        .rom_sel_n (rom_sel_n),
        .kbd_sel_n (kbd_sel_n),
        .vid_sel_n (vid_sel_n),
        .ram_sel_n (ram_sel_n)
    );

    // Expected {rom,kbd,vid,ram}, active low, derived from the requirements
    function automatic logic [3:0] expect_sel(input logic [15:0] a, input logic r,
                                              input logic s, input logic [9:0] st);
        logic [3:0] e;
        logic [2:0] sl;
        e = 4'b1111;
        sl = a[14:12];
        if (!s) begin
            if (!a[15]) begin
                if (st[sl]) begin
                    if (sl < 3'd3) e[3] = 1'b0;
                    else if (sl == 3'd3) begin
                        if (a[11:10] == 2'b10 && !r) e[2] = 1'b0;
                        if (a[11:10] == 2'b11) e[1] = 1'b0;
                    end else e[0] = 1'b0;
                end
            end else if (st[8 + a[14]]) begin
                e[0] = 1'b0;
            end
        end
        return e;
    endfunction

    function automatic logic [3:0] got_sel();
        return {rom_sel_n, kbd_sel_n, vid_sel_n, ram_sel_n};
    endfunction

    task automatic check(input string req, input logic [3:0] got, input logic [3:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: selects got %b expected %b (addr %h rd_n %b ras_n %b strap %b)",
                     req, got, exp, addr, rd_n, ras_n, strap);
        end
    endtask

    // Drive at a falling edge, let one rising edge pass, sample at the next falling edge
    task automatic apply(input logic [15:0] a, input logic r, input logic s, input logic [9:0] st);
        @(negedge clk);
        addr = a; rd_n = r; ras_n = s; strap = st;
        @(negedge clk);
    endtask

    task automatic t_reset();
        addr = 16'h01AC; rd_n = 1'b0; ras_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 during reset", got_sel(), 4'b1111);
        rst_n = 1'b1;
        apply(16'h0000, 1'b1, 1'b1, 10'h3FF);
        check("R1 after reset", got_sel(), 4'b1111);
    endtask

    task automatic t_landmarks();
        apply(16'h01AC, 1'b0, 1'b0, 10'h3FF);
        check("R5 rom 0x01AC", got_sel(), 4'b0111);
        apply(16'h380A, 1'b0, 1'b0, 10'h3FF);
        check("R6 kbd 0x380A", got_sel(), 4'b1011);
        apply(16'h3CAA, 1'b0, 1'b0, 10'h3FF);
        check("R7 vid 0x3CAA read", got_sel(), 4'b1101);
        apply(16'h3CAA, 1'b1, 1'b0, 10'h3FF);
        check("R7 vid 0x3CAA write", got_sel(), 4'b1101);
        apply(16'h2FFF, 1'b0, 1'b0, 10'h3FF);
        check("R5 rom top 0x2FFF", got_sel(), 4'b0111);
    endtask

    task automatic t_latency();
        apply(16'h0400, 1'b0, 1'b0, 10'h3FF);
        check("R2 rom after edge", got_sel(), 4'b0111);
        @(negedge clk);
        ras_n = 1'b1;
        #2ns;
        check("R2 held before edge", got_sel(), 4'b0111);
        @(negedge clk);
        check("R2 idle after edge", got_sel(), 4'b1111);
    endtask

    task automatic t_ras();
        apply(16'h01AC, 1'b0, 1'b1, 10'h3FF);
        check("R3 rom ras high", got_sel(), 4'b1111);
        apply(16'hC000, 1'b0, 1'b1, 10'h3FF);
        check("R3 upper ras high", got_sel(), 4'b1111);
        apply(16'h380A, 1'b0, 1'b1, 10'h3FF);
        check("R3 kbd ras high", got_sel(), 4'b1111);
    endtask

    task automatic t_low_bits();
        for (int k = 0; k < 10; k++) begin
            apply(16'h3800 | (16'h1 << k), 1'b0, 1'b0, 10'h3FF);
            check("R4 low bit kbd", got_sel(), 4'b1011);
        end
        apply(16'h3BFF, 1'b0, 1'b0, 10'h3FF);
        check("R4 kbd page top", got_sel(), 4'b1011);
        apply(16'h33FF, 1'b0, 1'b0, 10'h3FF);
        check("R8 gap 0x33FF", got_sel(), 4'b1111);
        apply(16'h3400, 1'b0, 1'b0, 10'h3FF);
        check("R8 gap 0x3400", got_sel(), 4'b1111);
    endtask

    task automatic t_read_qual();
        apply(16'h380A, 1'b1, 1'b0, 10'h3FF);
        check("R6 kbd write ignored", got_sel(), 4'b1111);
    endtask

    task automatic t_ram();
        apply(16'h4000, 1'b1, 1'b0, 10'h3FF);
        check("R9 ram 0x4000", got_sel(), 4'b1110);
        apply(16'h7FFF, 1'b0, 1'b0, 10'h3FF);
        check("R9 ram 0x7FFF", got_sel(), 4'b1110);
        apply(16'h8000, 1'b0, 1'b0, 10'h3FF);
        check("R10 ram 0x8000", got_sel(), 4'b1110);
        apply(16'hFFFF, 1'b1, 1'b0, 10'h3FF);
        check("R10 ram 0xFFFF", got_sel(), 4'b1110);
        apply(16'hC000, 1'b0, 1'b0, 10'h0FF);
        check("R10 upper straps open", got_sel(), 4'b1111);
        apply(16'hC000, 1'b0, 1'b0, 10'h200);
        check("R10 only strap 9", got_sel(), 4'b1110);
        apply(16'h8000, 1'b0, 1'b0, 10'h200);
        check("R10 strap 8 open", got_sel(), 4'b1111);
    endtask

    task automatic t_straps();
        apply(16'h1000, 1'b0, 1'b0, 10'h3FD);
        check("R11 rom slice 1 open", got_sel(), 4'b1111);
        apply(16'h0000, 1'b0, 1'b0, 10'h3FD);
        check("R11 rom slice 0 closed", got_sel(), 4'b0111);
        apply(16'h3CAA, 1'b0, 1'b0, 10'h3F7);
        check("R11 io slice open vid", got_sel(), 4'b1111);
        apply(16'h380A, 1'b0, 1'b0, 10'h3F7);
        check("R11 io slice open kbd", got_sel(), 4'b1111);
        apply(16'h5000, 1'b0, 1'b0, 10'h3DF);
        check("R11 ram slice 5 open", got_sel(), 4'b1111);
    endtask

    task automatic t_sweep();
        logic [9:0] straps [4] = '{10'h3FF, 10'h000, 10'h155, 10'h2AA};
        for (int si = 0; si < 4; si++) begin
            for (int r = 0; r < 2; r++) begin
                for (int p = 0; p < 64; p++) begin
                    logic [15:0] a;
                    logic [3:0]  g;
                    a = {p[5:0], 10'h2A5};
                    apply(a, r[0], 1'b0, straps[si]);
                    g = got_sel();
                    check("R12 sweep map", g, expect_sel(a, r[0], 1'b0, straps[si]));
                    checks++;
                    if ($countones(~g) > 1) begin
                        errors++;
                        $display("FAIL R12 several selects: got %b expected at most one low", g);
                    end
                end
            end
        end
    endtask

    initial begin
        #2ms;
        errors++;
        $display("FAIL watchdog: run did not finish, got hang expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_landmarks();
        t_latency();
        t_ras();
        t_low_bits();
        t_read_qual();
        t_ram();
        t_straps();
        t_sweep();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule